// File: doc/BRIEF.md
# Instruction Fetch Batch Tracker

This block sits between the instruction memory port and a processor's sequencer. It issues instruction read requests on an AXI4-style read address channel. Addresses run upward in steps of four from a boot address. Each request carries a transaction ID that names the current fetch batch. Returned words pass through an optional small buffer, which holds them while the execute side stalls (for example during a load or a long divide). They reach the consumer together with their program counter.

When the sequencer signals a redirect (a jump or a taken branch) with a target address, the block does three things:
- It moves to the next batch ID, which wraps modulo 2^ID_W.
- It reloads the fetch address from the target.
- It empties the buffer.

Responses still in flight for the old batch return later with the old ID. The block accepts them and discards them, without counting or waiting for them. The consumer therefore sees exactly the instructions from the new target onward. The number of undelivered requests in the current batch is limited by a credit count, so the buffer can never overflow.

With `USE_FIFO = 0` there is no buffer. A matching response is handed to the consumer in the same cycle, and the consumer's ready signal is fed back as the read-data ready.

Top module: `fetch_batch_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ar_valid` and `ins_valid` are 0. The first accepted request after reset carries address `BOOT_ADDR` and ID 0.
- R2: Accepted requests within one batch have addresses that rise by exactly 4. The first request of a new batch carries the redirect target.
- R3: After a redirect, new requests carry the previous batch ID plus one, modulo 2^ID_W. The only request with an older ID that may still be accepted is one that was already waiting on the address channel when the redirect arrived.
- R4: A response whose `r_id` differs from the current batch ID is accepted (`r_ready` is 1) and is never delivered.
- R5: Each delivered instruction has `ins_pc` equal to the batch target plus 4·k for the k-th delivery of the batch, with no gaps. `ins_data` is the word the memory returned for that address.
- R6: `ins_valid` is 0 in the cycle `redir_valid` is high and in the cycle after it. Anything buffered before the redirect is discarded.
- R7: The flush takes priority over the buffer write. A response that arrives in the redirect cycle is accepted and dropped whatever its ID.
- R8: Current-batch requests not yet delivered never exceed the credit count: `FIFO_DEPTH` when the buffer is present, `MAX_OUT` without it. The buffer never overflows.
- R9: With `USE_FIFO = 0`, a current-batch response appears on `ins_valid`/`ins_data` in the same cycle, and `r_ready` equals `ins_ready` for it.
- R10: With the buffer present and `ins_ready` held low, the block fills all `FIFO_DEPTH` entries. It delivers them in order, with no loss, once `ins_ready` returns.
- R11: While `ar_valid` is 1 and `ar_ready` is 0, `ar_valid`, `ar_addr` and `ar_id` hold their values in the next cycle, even across a redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Redirect: start a new batch at `redir_pc` |
| redir_pc | input | ADDR_W | Redirect target address |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted by memory |
| ar_addr | output | ADDR_W | Read request address |
| ar_id | output | ID_W | Read request ID (batch ID) |
| r_valid | input | 1 | Read response valid |
| r_ready | output | 1 | Read response accepted |
| r_data | input | DATA_W | Read response instruction word |
| r_id | input | ID_W | Read response ID |
| ins_valid | output | 1 | Instruction available to the execute side |
| ins_ready | input | 1 | Execute side takes the instruction |
| ins_data | output | DATA_W | Instruction word |
| ins_pc | output | ADDR_W | Address of the instruction word |

## Verification
The hardest situation to reach from the ports has three parts at once: a redirect, a full buffer, and old-batch responses still queued behind a waiting address request. On top of that, a response may land in the redirect cycle itself.

The bench drives a memory model that answers in order after a random latency of 0 to 3 cycles. It holds `ins_ready` low for 60 cycles every 400 so that the buffer fills. It then forces a redirect while the buffer is full, and mixes in random redirects with random `ar_ready`. This leaves old-ID words queued and an address request stranded across the redirect. The bench avoids a redirect when the next ID is still in flight. It runs the buffered and unbuffered variants side by side and checks every delivered word against the address sequence computed from the redirect targets.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  // Number of undelivered current-batch requests the block may hold.
  function automatic int credit_count(input int use_fifo, input int depth, input int max_out);
    return (use_fifo != 0) ? depth : max_out;
  endfunction

  // Counter width able to hold values 0..n.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fbt_addr_gen.sv
module fbt_addr_gen #(
  parameter int              ADDR_W    = 32,
  parameter int              ID_W      = 3,
  parameter int              CREDITS   = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  input  logic              deliver,
  input  logic              ar_ready,
  output logic              ar_valid,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [ID_W-1:0]   ar_id,
  output logic [ID_W-1:0]   cur_id,
  output logic [ADDR_W-1:0] dlv_pc
);
  localparam int CNT_W = fbt_pkg::count_width(CREDITS);
  localparam logic [CNT_W-1:0]  CRED_C = CNT_W'(CREDITS);
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(4);

  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] dlv_q;
  logic [CNT_W-1:0]  used_q;
  logic              arv_q;
  logic [ADDR_W-1:0] ara_q;
  logic [ID_W-1:0]   arid_q;

  logic slot_free;
  logic load;

  assign slot_free = !arv_q || ar_ready;
  assign load      = slot_free && (used_q < CRED_C) && !redir_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q   <= '0;
      next_q <= BOOT_ADDR;
      dlv_q  <= BOOT_ADDR;
      used_q <= '0;
      arv_q  <= 1'b0;
      ara_q  <= '0;
      arid_q <= '0;
    end else if (redir_valid) begin
      id_q   <= id_q + ID_W'(1);
      next_q <= redir_pc;
      dlv_q  <= redir_pc;
      used_q <= '0;
      if (ar_ready) arv_q <= 1'b0;
    end else begin
      if (load) begin
        arv_q  <= 1'b1;
        ara_q  <= next_q;
        arid_q <= id_q;
        next_q <= next_q + STEP;
      end else if (ar_ready) begin
        arv_q <= 1'b0;
      end
      used_q <= used_q + CNT_W'(load) - CNT_W'(deliver);
      if (deliver) dlv_q <= dlv_q + STEP;
    end
  end

  assign ar_valid = arv_q;
  assign ar_addr  = ara_q;
  assign ar_id    = arid_q;
  assign cur_id   = id_q;
  assign dlv_pc   = dlv_q;

  // Last accepted request, kept only for the sequence check below.
  logic [ADDR_W-1:0] lst_addr;
  logic [ID_W-1:0]   lst_id;
  logic              lst_vld;

  always_ff @(posedge clk) begin
    if (rst || redir_valid) begin
      lst_vld <= 1'b0;
    end else if (ar_valid && ar_ready) begin
      lst_vld  <= 1'b1;
      lst_addr <= ar_addr;
      lst_id   <= ar_id;
    end
  end

  // R2
  addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && lst_vld && ar_id == lst_id) |-> (ar_addr == lst_addr + STEP));

  // R11
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_id)));

  // R8
  credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used_q <= CRED_C);

endmodule

// File: rtl/fbt_resp_filter.sv
module fbt_resp_filter #(
  parameter int ID_W = 3
) (
  input  logic            r_valid,
  input  logic [ID_W-1:0] r_id,
  input  logic [ID_W-1:0] cur_id,
  input  logic            redir_valid,
  input  logic            sink_ready,
  output logic            keep,
  output logic            r_ready
);
  // A response is kept only when it belongs to the live batch and no
  // flush happens in the same cycle; everything else is swallowed.
  assign keep    = r_valid && (r_id == cur_id) && !redir_valid;
  assign r_ready = !keep || sink_ready;
endmodule

// File: rtl/fbt_fifo.sv
module fbt_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = fbt_pkg::count_width(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              do_push, do_pop;

  assign do_push = push && !flush;
  assign do_pop  = pop && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + PTR_W'(1);
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + PTR_W'(1);
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    do_push |-> ((cnt < FULL) || do_pop));

endmodule

// File: rtl/fetch_batch_tracker.sv
module fetch_batch_tracker #(
  parameter int              ADDR_W     = 32,
  parameter int              DATA_W     = 32,
  parameter int              ID_W       = 3,
  parameter int              USE_FIFO   = 1,
  parameter int              FIFO_DEPTH = 4,
  parameter int              MAX_OUT    = 2,
  parameter logic [ADDR_W-1:0] BOOT_ADDR  = ADDR_W'(32'h100)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [ID_W-1:0]   ar_id,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [ID_W-1:0]   r_id,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [DATA_W-1:0] ins_data,
  output logic [ADDR_W-1:0] ins_pc
);
  localparam int CREDITS = fbt_pkg::credit_count(USE_FIFO, FIFO_DEPTH, MAX_OUT);

  logic [ID_W-1:0] cur_id;
  logic            keep;
  logic            sink_ready;
  logic            deliver;

  assign deliver = ins_valid && ins_ready;

  fbt_addr_gen #(
    .ADDR_W   (ADDR_W),
    .ID_W     (ID_W),
    .CREDITS  (CREDITS),
    .BOOT_ADDR(BOOT_ADDR)
  ) u_addr_gen (
    .clk        (clk),
    .rst        (rst),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .deliver    (deliver),
    .ar_ready   (ar_ready),
    .ar_valid   (ar_valid),
    .ar_addr    (ar_addr),
    .ar_id      (ar_id),
    .cur_id     (cur_id),
    .dlv_pc     (ins_pc)
  );

  fbt_resp_filter #(.ID_W(ID_W)) u_filter (
    .r_valid    (r_valid),
    .r_id       (r_id),
    .cur_id     (cur_id),
    .redir_valid(redir_valid),
    .sink_ready (sink_ready),
    .keep       (keep),
    .r_ready    (r_ready)
  );

  generate
    if (USE_FIFO != 0) begin : g_buf
      logic              buf_valid;
      logic [DATA_W-1:0] buf_data;

      fbt_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (redir_valid),
        .push     (keep),
        .push_data(r_data),
        .pop      (deliver),
        .out_valid(buf_valid),
        .out_data (buf_data)
      );

      // Credits guarantee room, so the buffer always accepts.
      assign sink_ready = 1'b1;
      assign ins_valid  = buf_valid && !redir_valid;
      assign ins_data   = buf_data;
    end else begin : g_pass
      assign sink_ready = ins_ready;
      assign ins_valid  = keep;
      assign ins_data   = r_data;
    end
  endgenerate

  // R4
  stale_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_id != cur_id) |-> r_ready);

  // R6
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !ins_valid);

endmodule

// File: tb/fetch_batch_tracker_bench.sv
module fbt_harness #(
  parameter int USE_FIFO = 1,
  parameter int NCYC     = 4000
) (
  input logic clk,
  input logic rst
);
  localparam int AW = 32, DW = 32, IW = 3, DEPTH = 4, MAXO = 2;
  localparam int CRED = (USE_FIFO != 0) ? DEPTH : MAXO;
  localparam logic [AW-1:0] BOOT = 32'h0000_0100;

  logic          redir_valid = 1'b0;
  logic [AW-1:0] redir_pc = '0;
  logic          ar_valid;
  logic          ar_ready = 1'b0;
  logic [AW-1:0] ar_addr;
  logic [IW-1:0] ar_id;
  logic          r_valid = 1'b0;
  logic          r_ready;
  logic [DW-1:0] r_data = '0;
  logic [IW-1:0] r_id = '0;
  logic          ins_valid;
  logic          ins_ready = 1'b0;
  logic [DW-1:0] ins_data;
  logic [AW-1:0] ins_pc;

  fetch_batch_tracker #(
    .ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .USE_FIFO(USE_FIFO),
    .FIFO_DEPTH(DEPTH), .MAX_OUT(MAXO), .BOOT_ADDR(BOOT)
  ) u_fetch_batch_tracker (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_id(ar_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_id(r_id),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data), .ins_pc(ins_pc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (fifo=%0d) actual=%h expected=%h at %0t", req, USE_FIFO, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // In-order memory model: each request waits 0..3 cycles once at the head.
  logic [31:0] q_addr [64];
  logic [2:0]  q_id   [64];
  int          q_wait [64];
  int          q_head = 0;
  int          q_tail = 0;

  function automatic bit id_pending(input logic [2:0] id);
    for (int k = q_head; k < q_tail; k++)
      if (q_id[k % 64] == id) return 1'b1;
    return 1'b0;
  endfunction

  initial begin : drive
    logic [2:0]  bid, p_id, stale_id;
    logic [31:0] eaddr, epc, tgt, p_addr;
    int          issued, dlv, stale_drops, idle, ph;
    bit          first_ar, stale_allow, pend, was_redir, redir;
    bit          ar_fire, r_fire, ins_fire, r_stale;
    bid = '0; eaddr = BOOT; epc = BOOT; issued = 0; dlv = 0;
    stale_drops = 0; idle = 0; first_ar = 1'b1; stale_allow = 1'b0;
    pend = 1'b0; was_redir = 1'b0; p_addr = '0; p_id = '0; stale_id = '0;

    @(negedge clk);
    // R1: outputs quiet during reset
    check(!ar_valid && !ins_valid, "R1", {30'd0, ar_valid, ins_valid}, 0);
    while (rst) @(negedge clk);
    // R1: first cycle after reset still quiet
    check(!ar_valid && !ins_valid, "R1", {30'd0, ar_valid, ins_valid}, 0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      ph = cyc % 400;
      ins_ready = (ph >= 200 && ph < 260) ? 1'b0 : ($urandom_range(0, 3) != 0);
      ar_ready  = ($urandom_range(0, 3) != 0);
      redir = 1'b0;
      if (ph == 259) redir = !id_pending(bid + 3'd1);
      else if (cyc > 20 && (ph < 190 || ph > 270) && $urandom_range(0, 24) == 0)
        redir = !id_pending(bid + 3'd1);
      tgt = 32'h0000_2000 + {18'd0, 12'($urandom_range(0, 4095)), 2'b00};
      redir_valid = redir;
      redir_pc    = tgt;
      if (q_tail != q_head && q_wait[q_head % 64] == 0) begin
        r_valid = 1'b1;
        r_id    = q_id[q_head % 64];
        r_data  = word_at(q_addr[q_head % 64]);
      end else begin
        r_valid = 1'b0;
        r_id    = '0;
        r_data  = '0;
      end
      #1;
      ar_fire  = ar_valid && ar_ready;
      r_fire   = r_valid && r_ready;
      ins_fire = ins_valid && ins_ready;
      r_stale  = r_valid && (r_id != bid || redir);

      if (was_redir) check(!ins_valid, "R6", {31'd0, ins_valid}, 0);
      if (redir)     check(!ins_valid, "R6", {31'd0, ins_valid}, 0);
      if (pend)
        check(ar_valid && ar_addr == p_addr && ar_id == p_id, "R11", ar_addr, p_addr);
      if (r_stale) begin
        if (redir && r_id == bid) check(r_ready, "R7", {31'd0, r_ready}, 1);
        else                      check(r_ready, "R4", {31'd0, r_ready}, 1);
        if (USE_FIFO == 0) check(!ins_valid, "R4", {31'd0, ins_valid}, 0);
      end
      if (USE_FIFO == 0 && r_valid && !r_stale)
        check(ins_valid && ins_data == r_data && r_ready == ins_ready, "R9", ins_data, r_data);
      if (ph == 258)
        check(ins_valid && (issued - dlv) == CRED, "R10", issued - dlv, CRED);

      if (ar_fire) begin
        if (first_ar) begin
          check(ar_addr == BOOT && ar_id == 3'd0, "R1", ar_addr, BOOT);
          first_ar = 1'b0;
        end
        if (ar_id == bid) begin
          check(ar_addr == eaddr, "R2", ar_addr, eaddr);
          eaddr += 4;
          issued++;
          stale_allow = 1'b0;
        end else begin
          check(stale_allow && ar_id == stale_id, "R3", {29'd0, ar_id}, {29'd0, bid});
          stale_allow = 1'b0;
        end
        q_addr[q_tail % 64] = ar_addr;
        q_id[q_tail % 64]   = ar_id;
        q_wait[q_tail % 64] = $urandom_range(0, 3);
        q_tail++;
      end
      if (r_fire) begin
        if (r_stale) stale_drops++;
        q_head++;
      end
      if (q_tail != q_head && q_wait[q_head % 64] > 0) q_wait[q_head % 64]--;

      if (ins_fire) begin
        check(ins_pc == epc && ins_data == word_at(epc), "R5", ins_pc, epc);
        epc += 4;
        dlv++;
        idle = 0;
      end else begin
        idle++;
      end
      check((issued - dlv) <= CRED, "R8", issued - dlv, CRED);

      pend   = ar_valid && !ar_ready;
      p_addr = ar_addr;
      p_id   = ar_id;
      if (redir) begin
        stale_allow = ar_valid && !ar_ready;
        stale_id    = ar_id;
        bid    = bid + 3'd1;
        eaddr  = tgt;
        epc    = tgt;
        issued = 0;
        dlv    = 0;
      end
      was_redir = redir;
      if (idle > 600) begin
        check(1'b0, "watchdog", idle, 0);
        break;
      end
      @(negedge clk);
    end
    // R4: old-batch responses were actually produced and dropped
    check(stale_drops > 0, "R4", stale_drops, 1);
    done = 1'b1;
  end
endmodule

module fetch_batch_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  bit   timed_out = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fbt_harness #(.USE_FIFO(1)) h_fifo (.clk(clk), .rst(rst));
  fbt_harness #(.USE_FIFO(0)) h_pass (.clk(clk), .rst(rst));

  initial begin
    int total, bad;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    fork
      wait (h_fifo.done && h_pass.done);
      begin
        repeat (LIMIT) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    total = h_fifo.checks + h_pass.checks;
    bad   = h_fifo.errors + h_pass.errors;
    if (timed_out) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", LIMIT);
    end
    $display("  Simulation finished: %0d checks, %0d errors", total, bad);
    $finish;
  end
endmodule